// File: doc/BRIEF.md
# Trimmed-Mean Sample Filter

This block turns a stream of raw readings from one sensor into filtered results. A 3-bit mode code picks the window. The block can pass one reading straight through, average two readings, or collect a larger window and average it after throwing away the single smallest and the single largest reading. Collecting 4, 6, 10 or 18 readings yields averages over 2, 4, 8 or 16 readings.

A bypass input overrides the mode and returns every reading as soon as it arrives. The block keeps a running sum and tracks the minimum and maximum as readings come in. When the final reading of a window arrives, it subtracts the two extremes, shifts right by the log2 of the averaging count and truncates. The result appears one clock later with a one-cycle valid pulse. The block serves one sensor. Choosing between sensors and timing the readings are the job of the surrounding logic.

Top module: `tmean_filter`

## Requirements
- R1: After reset, `res_valid` is 0, `res_data` is 0, and the next accepted sample opens a new window.
- R2: Mode 3'b000 returns each sample unchanged, with `res_valid` high in the cycle after the sample is accepted.
- R3: Mode 3'b001 collects 2 samples and outputs (a+b)>>1, truncated. The first sample produces no result.
- R4: Mode 3'b010 collects 4 samples and outputs (sum-min-max)>>1.
- R5: Mode 3'b011 collects 6 samples and outputs (sum-min-max)>>2.
- R6: Mode 3'b100 collects 10 samples and outputs (sum-min-max)>>3.
- R7: Mode 3'b101 collects 18 samples and outputs (sum-min-max)>>4. Only one copy of the minimum and one copy of the maximum is removed, even when several samples share those values.
- R8: While `bypass` is 1, each accepted sample is output unchanged one cycle later, whatever the mode. Any partly filled window is discarded, and the next non-bypass sample opens a new window.
- R9: The mode is taken from the first sample of a window. Changes on `mode` during the rest of the window have no effect on its length or its result.
- R10: `res_valid` is high for exactly one cycle, and only in the cycle after the last sample of a window is accepted. Idle cycles between samples do not disturb the window.
- R11: Reserved codes 3'b110 and 3'b111 behave exactly as 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | A sample is presented this cycle |
| smp_data | input | DATA_W | Raw sample value, unsigned |
| mode | input | 3 | Filter mode code |
| bypass | input | 1 | Output each sample directly, ignoring the mode |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_data | output | DATA_W | Filtered result |

## Verification
The bench builds the block with the default DATA_W of 15. At that width, full-scale samples over an 18-sample window drive the running sum close to the top of its 20-bit accumulator, so the headroom of the widest window is exercised. Random windows in every mode use random idle gaps between samples and a mode input that changes after the first sample of each window. Directed cases cover truncation of odd sums, repeated minima and maxima, the reserved codes, and a bypass sample arriving in the middle of a window.

// File: rtl/tmf_pkg.sv
// Shared types and mode decoding for the trimmed-mean filter.
// Assumes the largest window is 18 samples and the largest shift is 4.
package tmf_pkg;
    localparam int MAX_WIN  = 18;
    localparam int CNT_W    = $clog2(MAX_WIN + 1);
    localparam int SHIFT_W  = 3;
    localparam int GROW_W   = 5;   // sum growth bits: 2^5 >= MAX_WIN

    typedef struct packed {
        logic [CNT_W-1:0]   win;    // samples in the window
        logic [SHIFT_W-1:0] shift;  // log2 of averaging count
        logic               trim;   // drop min and max first
    } mode_cfg_t;

    // Map a 3-bit mode code onto its window, shift and trim setting.
    function automatic mode_cfg_t decode_mode(input logic [2:0] code);
        mode_cfg_t c;
        case (code)
            3'd1:    c = '{win: CNT_W'(2),  shift: SHIFT_W'(1), trim: 1'b0};
            3'd2:    c = '{win: CNT_W'(4),  shift: SHIFT_W'(1), trim: 1'b1};
            3'd3:    c = '{win: CNT_W'(6),  shift: SHIFT_W'(2), trim: 1'b1};
            3'd4:    c = '{win: CNT_W'(10), shift: SHIFT_W'(3), trim: 1'b1};
            3'd5:    c = '{win: CNT_W'(18), shift: SHIFT_W'(4), trim: 1'b1};
            default: c = '{win: CNT_W'(1),  shift: SHIFT_W'(0), trim: 1'b0};
        endcase
        return c;
    endfunction
endpackage

// File: rtl/tmf_mode_sel.sv
// Chooses the mode in force for the current sample. A bypass sample is
// treated as a one-sample window. The first sample of a window takes the
// live mode input. Later samples use the mode latched at window start.
module tmf_mode_sel
    import tmf_pkg::*;
(
    input  logic             bypass,
    input  logic [2:0]       mode_in,
    input  logic [2:0]       mode_q,
    input  logic [CNT_W-1:0] cnt_q,
    output mode_cfg_t        cfg
);
    logic [2:0] eff_mode;

    // Select the effective mode code and decode it.
    always_comb begin
        if (bypass)
            eff_mode = 3'd0;
        else if (cnt_q == '0)
            eff_mode = mode_in;
        else
            eff_mode = mode_q;
        cfg = decode_mode(eff_mode);
    end
endmodule

// File: rtl/tmf_accum.sv
// Holds the running sum, minimum, maximum and sample count of the open
// window. It also exposes the values that include the incoming sample, so
// the result stage can finish in the same cycle as the last sample.
// Assumes cfg comes from tmf_mode_sel for the same sample.
module tmf_accum
    import tmf_pkg::*;
#(
    parameter int DATA_W = 15,
    parameter int SUM_W  = DATA_W + GROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              bypass,
    input  logic [2:0]        mode_in,
    input  mode_cfg_t         cfg,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [2:0]        mode_q,
    output logic [SUM_W-1:0]  sum_n,
    output logic [DATA_W-1:0] min_n,
    output logic [DATA_W-1:0] max_n,
    output logic              last
);
    logic [SUM_W-1:0]  sum_q;
    logic [DATA_W-1:0] min_q, max_q;
    logic [CNT_W-1:0]  cnt_base;
    logic              first;
    logic [SUM_W-1:0]  smp_ext;

    // Fold the incoming sample into the window's running statistics.
    always_comb begin
        first    = (cnt_q == '0) || bypass;
        cnt_base = first ? '0 : cnt_q;
        smp_ext  = {{(SUM_W-DATA_W){1'b0}}, smp_data};
        sum_n    = first ? smp_ext  : sum_q + smp_ext;
        min_n    = (first || smp_data < min_q) ? smp_data : min_q;
        max_n    = (first || smp_data > max_q) ? smp_data : max_q;
        last     = smp_valid && ((cnt_base + CNT_W'(1)) == cfg.win);
    end

    // Register the window state on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mode_q <= 3'd0;
            sum_q  <= '0;
            min_q  <= '0;
            max_q  <= '0;
        end else if (smp_valid) begin
            cnt_q <= last ? '0 : cnt_base + CNT_W'(1);
            sum_q <= sum_n;
            min_q <= min_n;
            max_q <= max_n;
            if (first && !bypass)
                mode_q <= mode_in;
        end
    end
endmodule

// File: rtl/tmf_result.sv
// Forms the filtered value when a window closes: it removes the extremes
// if the mode trims, shifts right and truncates, then registers the value
// with a one-cycle valid pulse. Assumes sum >= min + max whenever trimming.
module tmf_result
    import tmf_pkg::*;
#(
    parameter int DATA_W = 15,
    parameter int SUM_W  = DATA_W + GROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last,
    input  mode_cfg_t         cfg,
    input  logic [SUM_W-1:0]  sum_n,
    input  logic [DATA_W-1:0] min_n,
    input  logic [DATA_W-1:0] max_n,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);
    logic [SUM_W-1:0] trimmed;
    logic [SUM_W-1:0] scaled;

    // Remove the extremes when trimming, then divide by a power of two.
    always_comb begin
        trimmed = cfg.trim
                ? sum_n - {{(SUM_W-DATA_W){1'b0}}, min_n}
                        - {{(SUM_W-DATA_W){1'b0}}, max_n}
                : sum_n;
        scaled  = trimmed >> cfg.shift;
    end

    // Register the result and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= last;
            if (last)
                res_data <= scaled[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/tmean_filter.sv
// Top level of the trimmed-mean filter for one sensor. It connects the
// mode selector, the window accumulator and the result stage. A result
// appears one cycle after the sample that closes its window.
module tmean_filter
    import tmf_pkg::*;
#(
    parameter int DATA_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [2:0]        mode,
    input  logic              bypass,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);
    localparam int SUM_W = DATA_W + GROW_W;

    mode_cfg_t         cfg;
    logic [CNT_W-1:0]  cnt_q;
    logic [2:0]        mode_q;
    logic [SUM_W-1:0]  sum_n;
    logic [DATA_W-1:0] min_n, max_n;
    logic              last;

    tmf_mode_sel i_sel (
        .bypass (bypass),
        .mode_in(mode),
        .mode_q (mode_q),
        .cnt_q  (cnt_q),
        .cfg    (cfg)
    );

    tmf_accum #(.DATA_W(DATA_W), .SUM_W(SUM_W)) i_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .bypass   (bypass),
        .mode_in  (mode),
        .cfg      (cfg),
        .cnt_q    (cnt_q),
        .mode_q   (mode_q),
        .sum_n    (sum_n),
        .min_n    (min_n),
        .max_n    (max_n),
        .last     (last)
    );

    tmf_result #(.DATA_W(DATA_W), .SUM_W(SUM_W)) i_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .last     (last),
        .cfg      (cfg),
        .sum_n    (sum_n),
        .min_n    (min_n),
        .max_n    (max_n),
        .res_valid(res_valid),
        .res_data (res_data)
    );
endmodule

// File: rtl/tmf_checker.sv
// Temporal checks for tmean_filter, attached through bind. It observes the
// ports and the window count that the accumulator drives.
module tmf_checker
    import tmf_pkg::*;
#(
    parameter int DATA_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [DATA_W-1:0] smp_data,
    input logic [2:0]        mode,
    input logic              bypass,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic [CNT_W-1:0]  cnt_q
);
    // R2 and R11: single-sample codes pass the sample through.
    assert_single_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !bypass && cnt_q == '0 &&
         (mode == 3'd0 || mode == 3'd6 || mode == 3'd7))
        |=> (res_valid && res_data == $past(smp_data)));

    assert_bypass_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && bypass) |=> (res_valid && res_data == $past(smp_data)));

    assert_pair_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !bypass && cnt_q == '0 && mode == 3'd1) |=> !res_valid);

    assert_res_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(smp_valid));
endmodule

bind tmean_filter tmf_checker #(.DATA_W(DATA_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .smp_data (smp_data),
    .mode     (mode),
    .bypass   (bypass),
    .res_valid(res_valid),
    .res_data (res_data),
    .cnt_q    (cnt_q)
);

// File: tb/test_tmean_filter.sv
`timescale 1ns/1ps
module test_tmean_filter;
    localparam int DW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic [2:0]    mode = 3'd0;
    logic          bypass = 1'b0;
    logic          res_valid;
    logic [DW-1:0] res_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [DW-1:0] win_buf [18];

    always #4 clk = ~clk;

    tmean_filter #(.DATA_W(DW)) i_tmean_filter (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .mode(mode), .bypass(bypass), .res_valid(res_valid), .res_data(res_data)
    );

    function automatic int win_len(input logic [2:0] m);
        case (m)
            3'd1: return 2;  3'd2: return 4;  3'd3: return 6;
            3'd4: return 10; 3'd5: return 18; default: return 1;
        endcase
    endfunction

    function automatic int win_shift(input logic [2:0] m);
        case (m)
            3'd1: return 1; 3'd2: return 1; 3'd3: return 2;
            3'd4: return 3; 3'd5: return 4; default: return 0;
        endcase
    endfunction

    function automatic logic [DW-1:0] expect_val(input logic [2:0] m);
        int n = win_len(m);
        int s = 0;
        int lo = win_buf[0];
        int hi = win_buf[0];
        for (int i = 0; i < n; i++) begin
            s += int'(win_buf[i]);
            if (int'(win_buf[i]) < lo) lo = int'(win_buf[i]);
            if (int'(win_buf[i]) > hi) hi = int'(win_buf[i]);
        end
        if (m >= 3'd2 && m <= 3'd5) s = s - lo - hi;
        return DW'(s >> win_shift(m));
    endfunction

    task automatic check(input bit ok, input string req,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Feed one window from win_buf. The mode changes randomly after the
    // first sample (R9). Idle gaps are inserted between samples (R10).
    task automatic run_win(input logic [2:0] m, input int gap, input string req);
        int n = win_len(m);
        logic [DW-1:0] exp = expect_val(m);
        for (int i = 0; i < n; i++) begin
            smp_valid = 1'b1;
            smp_data  = win_buf[i];
            mode      = (i == 0) ? m : 3'($urandom);
            @(negedge clk);
            smp_valid = 1'b0;
            if (i < n - 1) begin
                check(res_valid == 1'b0, "R10", int'(res_valid), 0);
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    check(res_valid == 1'b0, "R10", int'(res_valid), 0);
                end
            end else begin
                check(res_valid == 1'b1, req, int'(res_valid), 1);
                check(res_data == exp, req, int'(res_data), int'(exp));
            end
        end
        @(negedge clk);
        check(res_valid == 1'b0, "R10", int'(res_valid), 0);
    endtask

    task automatic fill_rand();
        for (int i = 0; i < 18; i++) win_buf[i] = DW'($urandom);
    endtask

    initial begin
        void'($urandom(32'd5417));
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R1", int'(res_valid), 0);
        check(res_data == '0, "R1", int'(res_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid == 1'b0, "R1", int'(res_valid), 0);

        // R2 and R11: single-sample codes.
        fill_rand(); run_win(3'd0, 0, "R2");
        fill_rand(); run_win(3'd6, 1, "R11");
        fill_rand(); run_win(3'd7, 0, "R11");

        // R3: odd sum truncates.
        win_buf[0] = 15'd1; win_buf[1] = 15'd2; run_win(3'd1, 0, "R3");

        // R4: repeated extremes drop only one copy each.
        win_buf[0] = 15'd5; win_buf[1] = 15'd5; win_buf[2] = 15'd9; win_buf[3] = 15'd9;
        run_win(3'd2, 1, "R4");

        // R7: full scale over the widest window.
        for (int i = 0; i < 18; i++) win_buf[i] = 15'h7FFF;
        run_win(3'd5, 0, "R7");

        fill_rand(); run_win(3'd3, 2, "R5");
        fill_rand(); run_win(3'd4, 0, "R6");
        fill_rand(); run_win(3'd5, 1, "R7");

        // R8: a bypass sample in the middle of a window, then a fresh window.
        fill_rand();
        for (int i = 0; i < 3; i++) begin
            smp_valid = 1'b1; smp_data = DW'($urandom); mode = 3'd5;
            @(negedge clk);
            smp_valid = 1'b0;
        end
        smp_valid = 1'b1; bypass = 1'b1; smp_data = 15'd1234; mode = 3'd4;
        @(negedge clk);
        smp_valid = 1'b0; bypass = 1'b0;
        check(res_valid == 1'b1, "R8", int'(res_valid), 1);
        check(res_data == 15'd1234, "R8", int'(res_data), 1234);
        run_win(3'd2, 0, "R8");

        // R9: mode changes after the first sample (random in run_win).
        for (int k = 0; k < 40; k++) begin
            logic [2:0] m = 3'($urandom);
            fill_rand();
            run_win(m, int'($urandom % 3), "R9");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule